// File: doc/BRIEF.md
# Amplifier Control and Fault-Status Serial Slave

This block is the two-wire serial (I2C) target that sits in front of a four-channel power amplifier controller. The host writes two command bytes that set the amplifier's operating controls: diagnostic enable, DC-offset test enable, per-axle gain, per-axle mute, the clip-detector threshold, standby exit, the load thresholds used by the diagnostics, and the efficiency mode per side. The host reads back four status bytes. Each status byte carries the five fault flags of one channel, and the upper bits carry a few global indications.

The raw SCL and SDA lines are synchronised to the system clock and edge-detected inside the block. The block drives SDA only through an open-drain enable. Status is frozen into a shadow copy at the moment the read address is acknowledged, so fault updates that arrive during a transfer cannot tear the bytes in flight. When a read transaction is closed by a STOP or by a repeated START, the block pulses a one-cycle re-arm strobe. This strobe makes the diagnostic engines start a fresh measurement cycle. As a result, a fault that has cleared only disappears on the second read after it clears.

Top module: `amp_ctrl_i2c_slave`

## Requirements
- R1: Only the 7-bit address 1101100 is accepted, with the R/W bit in bit 0 of the address byte (0 = write, so 0xD8 writes and 0xD9 reads). Any other address leaves SDA released for the rest of the transaction, leaves every control output unchanged and causes no re-arm.
- R2: The first byte written after the address sets the controls as follows. Bit 6 is diagnostic enable, bit 5 is offset-test enable, bit 4 is front low gain (1 = 16 dB) and bit 3 is rear low gain. Bit 2 is front play (1 = unmuted), bit 1 is rear play, and bit 0 is the high clip threshold (1 = 10 %, 0 = 2 %). Bit 7 has no effect.
- R3: The second written byte sets the remaining controls. Bit 4 leaves standby (run), bit 3 selects line-driver diagnostic thresholds, bit 1 selects high efficiency on the right side and bit 0 selects it on the left side. Bits 7, 6, 5 and 2 have no effect. Control outputs change only after a written byte is complete.
- R4: Data bytes after the second one in a write are acknowledged and have no effect on any control output.
- R5: The slave acknowledges a matching address byte and every written data byte by holding SDA low for the ninth clock, and releases SDA after that clock.
- R6: The slave changes its SDA drive only while SCL is low. Read data is sent MSB first.
- R7: After reset, all control outputs are 0 (standby, muted, diagnostics off) and SDA is released. A STOP always releases SDA and returns the slave to idle.
- R8: A read returns four bytes in channel order 0 (LF), 1 (LR), 2 (RF), 3 (RR). Within each byte, bit 4 is the diagnostic kind, bit 3 is short load, bit 2 is open load or offset, bit 1 is short to supply and bit 0 is short to ground. On the flag input, channel k occupies bits 5k+4 down to 5k in the same order. The bytes are a snapshot taken when the read address is acknowledged; input changes after that point show only on the next read.
- R9: Byte 0 carries the thermal warning in bit 7 and cycle-done in bit 6. Byte 1 carries offset-test active in bit 7. Byte 2 carries the run control in bit 7 and diagnostic enable in bit 6. All other upper bits (7 to 5) of the status bytes are 0.
- R10: A read transaction that ends with a STOP or a repeated START produces exactly one one-cycle re-arm pulse. Write transactions and rejected addresses produce none.
- R11: A master NACK ends the read: SDA stays released until the next START. If the master keeps acknowledging, the fifth and later bytes wrap back to byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| ch_flags_i | input | 20 | Per-channel fault flags, 5 bits per channel |
| therm_warn_i | input | 1 | Thermal warning indication |
| cycle_done_i | input | 1 | Diagnostic cycle terminated |
| ofs_active_i | input | 1 | Offset test running |
| diag_en_o | output | 1 | Diagnostics enable |
| ofs_en_o | output | 1 | Offset test enable |
| gain_front_lo_o | output | 1 | Front channels at low gain |
| gain_rear_lo_o | output | 1 | Rear channels at low gain |
| play_front_o | output | 1 | Front channels unmuted |
| play_rear_o | output | 1 | Rear channels unmuted |
| clip_hi_o | output | 1 | Clip detector high threshold |
| run_o | output | 1 | Amplifier out of standby |
| line_diag_o | output | 1 | Line-driver diagnostic thresholds |
| heff_right_o | output | 1 | Right side high efficiency |
| heff_left_o | output | 1 | Left side high efficiency |
| rearm_o | output | 1 | One-cycle diagnostic restart strobe |

## Verification
If the bit counter or the state register goes wrong, the effect reaches the pins within one byte time. The acknowledge either moves off the ninth clock or goes missing, or the SDA drive changes while SCL is high; the bench watches the open-drain enable continuously for both. A broken snapshot or byte index shows as wrong status bytes in the same read, and the fields are placed so that every flag bit lands at a distinct position. A stale read-in-progress flag shows as a missing or extra re-arm pulse when the transaction closes, and the bench counts these pulses around every transaction.

// File: rtl/amp_i2c_pkg.sv
package amp_i2c_pkg;
   localparam int CH_NUM  = 4;
   localparam int FLAG_W  = 5;
   localparam int IDX_W   = $clog2(CH_NUM);
   localparam int SNAP_W  = CH_NUM * 8;

   typedef struct packed {
      logic diag_en;
      logic ofs_en;
      logic gain_front_lo;
      logic gain_rear_lo;
      logic play_front;
      logic play_rear;
      logic clip_hi;
   } cmd_first_t;

   typedef struct packed {
      logic run;
      logic line_diag;
      logic heff_right;
      logic heff_left;
   } cmd_second_t;

   typedef enum logic [2:0] {
      BS_IDLE, BS_ADDR, BS_AACK, BS_WDAT, BS_WACK, BS_RDAT, BS_RACK
   } bus_st_t;
endpackage

// File: rtl/amp_i2c_sync.sv
module amp_i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic [1:0] raw, line_s, line_q;

   assign raw = {scl_i, sda_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign line_s[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 2'b11;
      else        line_q <= line_s;
   end

   assign scl_s    = line_s[1];
   assign sda_s    = line_s[0];
   assign scl_rise = line_s[1] & ~line_q[1];
   assign scl_fall = ~line_s[1] & line_q[1];
   assign start_ev = line_s[1] & line_q[1] & line_q[0] & ~line_s[0];
   assign stop_ev  = line_s[1] & line_q[1] & ~line_q[0] & line_s[0];
endmodule

// File: rtl/amp_i2c_fsm.sv
module amp_i2c_fsm
   import amp_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1101100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic [SNAP_W-1:0] snap_i,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic [1:0]        wr_sel,
   output logic [7:0]        wr_data,
   output logic              snap_ld,
   output logic              rearm
);
   bus_st_t          st;
   logic [3:0]       cnt;
   logic [7:0]       sh, tx;
   logic             rw, mack, rd_live;
   logic [IDX_W-1:0] ridx;
   logic [7:0]       nxt_byte;

   assign nxt_byte = snap_i[ridx*8 +: 8];
   assign wr_data  = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= BS_IDLE; cnt <= '0; sh <= '0; tx <= '0; rw <= 1'b0;
         mack <= 1'b0; rd_live <= 1'b0; ridx <= '0; sda_oe <= 1'b0;
         wr_stb <= 1'b0; wr_sel <= '0; snap_ld <= 1'b0; rearm <= 1'b0;
      end else begin
         wr_stb  <= 1'b0;
         snap_ld <= 1'b0;
         rearm   <= 1'b0;
         if (start_ev) begin
            rearm   <= rd_live;
            rd_live <= 1'b0;
            st      <= BS_ADDR;
            cnt     <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_ev) begin
            rearm   <= rd_live;
            rd_live <= 1'b0;
            st      <= BS_IDLE;
            sda_oe  <= 1'b0;
         end else begin
            unique case (st)
               BS_ADDR: begin
                  if (scl_rise && cnt != 4'd8) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end
                  if (scl_fall && cnt == 4'd8) begin
                     if (sh[7:1] == DEV_ADDR) begin
                        st      <= BS_AACK;
                        sda_oe  <= 1'b1;
                        rw      <= sh[0];
                        snap_ld <= sh[0];
                     end else begin
                        st <= BS_IDLE;
                     end
                  end
               end
               BS_AACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rw) begin
                        st      <= BS_RDAT;
                        tx      <= snap_i[7:0];
                        sda_oe  <= ~snap_i[7];
                        ridx    <= IDX_W'(1);
                        rd_live <= 1'b1;
                     end else begin
                        st     <= BS_WDAT;
                        sda_oe <= 1'b0;
                        wr_sel <= '0;
                     end
                  end
               end
               BS_WDAT: begin
                  if (scl_rise && cnt != 4'd8) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end
                  if (scl_fall && cnt == 4'd8) begin
                     st     <= BS_WACK;
                     sda_oe <= 1'b1;
                     wr_stb <= 1'b1;
                  end
               end
               BS_WACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     st     <= BS_WDAT;
                     cnt    <= '0;
                     if (wr_sel != 2'd2) wr_sel <= wr_sel + 2'd1;
                  end
               end
               BS_RDAT: begin
                  if (scl_rise) cnt <= cnt + 4'd1;
                  if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        st     <= BS_RACK;
                     end else begin
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= ~tx[6];
                     end
                  end
               end
               BS_RACK: begin
                  if (scl_rise) mack <= ~sda_s;
                  if (scl_fall) begin
                     cnt <= '0;
                     if (mack) begin
                        st     <= BS_RDAT;
                        tx     <= nxt_byte;
                        sda_oe <= ~nxt_byte[7];
                        ridx   <= ridx + IDX_W'(1);
                     end else begin
                        st <= BS_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R6: drive changes only with SCL low (bus conditions excluded)
   p_oe_steady_scl_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));
   // R10: re-arm is a single-cycle pulse
   p_rearm_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> !rearm);
   // R7: a STOP always releases the line
   p_release_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe);
   // R1: after a rejected address nothing is driven
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BS_IDLE && !start_ev) |=> !sda_oe);
endmodule

// File: rtl/amp_ctrl_regs.sv
module amp_ctrl_regs
   import amp_i2c_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_stb,
   input  logic [1:0]  wr_sel,
   input  logic [7:0]  wr_data,
   output cmd_first_t  cmd1,
   output cmd_second_t cmd2
);
   logic unused_bits;
   assign unused_bits = ^{wr_data[7], wr_data[5], wr_data[2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd1 <= '0;
         cmd2 <= '0;
      end else if (wr_stb) begin
         case (wr_sel)
            2'd0:    cmd1 <= wr_data[6:0];
            2'd1:    cmd2 <= {wr_data[4], wr_data[3], wr_data[1], wr_data[0]};
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/amp_stat_snap.sv
module amp_stat_snap
   import amp_i2c_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     snap_ld,
   input  logic [CH_NUM*FLAG_W-1:0] ch_flags,
   input  logic                     therm_warn,
   input  logic                     cycle_done,
   input  logic                     ofs_active,
   input  logic                     run,
   input  logic                     diag_en,
   output logic [SNAP_W-1:0]        snap
);
   logic [2:0] top_bits [CH_NUM];

   always_comb begin
      for (int k = 0; k < CH_NUM; k++) top_bits[k] = 3'b000;
      top_bits[0] = {therm_warn, cycle_done, 1'b0};
      top_bits[1] = {ofs_active, 2'b00};
      top_bits[2] = {run, diag_en, 1'b0};
   end

   for (genvar k = 0; k < CH_NUM; k++) begin : g_byte
      logic [7:0] live;
      assign live = {top_bits[k], ch_flags[k*FLAG_W +: FLAG_W]};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       snap[k*8 +: 8] <= '0;
         else if (snap_ld) snap[k*8 +: 8] <= live;
      end
   end
endmodule

// File: rtl/amp_ctrl_i2c_slave.sv
module amp_ctrl_i2c_slave
   import amp_i2c_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'b1101100
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        sda_oe_o,
   input  logic [19:0] ch_flags_i,
   input  logic        therm_warn_i,
   input  logic        cycle_done_i,
   input  logic        ofs_active_i,
   output logic        diag_en_o,
   output logic        ofs_en_o,
   output logic        gain_front_lo_o,
   output logic        gain_rear_lo_o,
   output logic        play_front_o,
   output logic        play_rear_o,
   output logic        clip_hi_o,
   output logic        run_o,
   output logic        line_diag_o,
   output logic        heff_right_o,
   output logic        heff_left_o,
   output logic        rearm_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CH_NUM * FLAG_W != 20) begin : g_bad_flags
      $error("flag port width does not match channel layout");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic wr_stb, snap_ld;
   logic [1:0] wr_sel;
   logic [7:0] wr_data;
   logic [SNAP_W-1:0] snap;
   cmd_first_t  cmd1;
   cmd_second_t cmd2;

   amp_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev));

   amp_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
      .stop_ev(stop_ev), .snap_i(snap), .sda_oe(sda_oe_o), .wr_stb(wr_stb),
      .wr_sel(wr_sel), .wr_data(wr_data), .snap_ld(snap_ld), .rearm(rearm_o));

   amp_ctrl_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
      .wr_data(wr_data), .cmd1(cmd1), .cmd2(cmd2));

   amp_stat_snap u_snap (
      .clk(clk), .rst_n(rst_n), .snap_ld(snap_ld), .ch_flags(ch_flags_i),
      .therm_warn(therm_warn_i), .cycle_done(cycle_done_i),
      .ofs_active(ofs_active_i), .run(cmd2.run), .diag_en(cmd1.diag_en),
      .snap(snap));

   assign diag_en_o       = cmd1.diag_en;
   assign ofs_en_o        = cmd1.ofs_en;
   assign gain_front_lo_o = cmd1.gain_front_lo;
   assign gain_rear_lo_o  = cmd1.gain_rear_lo;
   assign play_front_o    = cmd1.play_front;
   assign play_rear_o     = cmd1.play_rear;
   assign clip_hi_o       = cmd1.clip_hi;
   assign run_o           = cmd2.run;
   assign line_diag_o     = cmd2.line_diag;
   assign heff_right_o    = cmd2.heff_right;
   assign heff_left_o     = cmd2.heff_left;

   // R3: controls move only in the cycle after a completed written byte
   p_ctrl_only_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({cmd1, cmd2}) |-> $past(wr_stb));
   // R8: the shadow copy moves only when a read address is acknowledged
   p_snap_only_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(snap) |-> $past(snap_ld));
endmodule

// File: tb/amp_ctrl_i2c_slave_tb.sv
module amp_ctrl_i2c_slave_tb;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 8;

   logic clk = 0, rst_n = 0;
   logic m_scl = 1, m_sda = 1;
   logic sda_oe;
   logic [19:0] flags = '0;
   logic therm = 0, cdone = 0, ofsact = 0;
   logic diag_en, ofs_en, gfl, grl, pf, pr, cliph, run, lined, hr, hl, rearm;
   logic sda_line;
   int total = 0, bad = 0, rearm_cnt = 0, r6_viol = 0;
   bit finished = 0;

   assign sda_line = m_sda & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   amp_ctrl_i2c_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .ch_flags_i(flags), .therm_warn_i(therm), .cycle_done_i(cdone),
      .ofs_active_i(ofsact), .diag_en_o(diag_en), .ofs_en_o(ofs_en),
      .gain_front_lo_o(gfl), .gain_rear_lo_o(grl), .play_front_o(pf),
      .play_rear_o(pr), .clip_hi_o(cliph), .run_o(run), .line_diag_o(lined),
      .heff_right_o(hr), .heff_left_o(hl), .rearm_o(rearm));

   always @(posedge clk) if (rst_n && rearm) rearm_cnt++;

   // R6 monitor: drive must not change across an SCL-high interval
   logic p_scl = 1, p_oe = 0;
   always @(negedge clk) begin
      if (rst_n && m_scl && p_scl && (sda_oe != p_oe)) r6_viol++;
      p_scl <= m_scl;
      p_oe  <= sda_oe;
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; tick(Q); m_scl = 1; tick(Q); m_scl = 0; tick(Q);
      end
      m_sda = 1; tick(Q); m_scl = 1; tick(Q/2);
      acked = ~sda_line;
      tick(Q/2); m_scl = 0; tick(Q);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      m_sda = 1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q); m_scl = 1; tick(Q/2); b[i] = sda_line; tick(Q/2); m_scl = 0;
      end
      tick(Q); m_sda = give_ack ? 1'b0 : 1'b1;
      m_scl = 1; tick(Q); m_scl = 0; tick(Q); m_sda = 1;
   endtask

   function automatic logic [10:0] ctrl_now();
      return {diag_en, ofs_en, gfl, grl, pf, pr, cliph, run, lined, hr, hl};
   endfunction

   function automatic logic [10:0] ctrl_exp(logic [7:0] c1, logic [7:0] c2);
      return {c1[6:0], c2[4], c2[3], c2[1], c2[0]};
   endfunction

   function automatic logic [7:0] stat_exp(int k, logic [19:0] fl, logic th, logic dn,
                                           logic oa, logic rn, logic de);
      logic [7:0] b;
      b = {3'b000, fl[k*5 +: 5]};
      if (k == 0) begin b[7] = th; b[6] = dn; end
      if (k == 1) b[7] = oa;
      if (k == 2) begin b[7] = rn; b[6] = de; end
      return b;
   endfunction

   task automatic do_write(logic [7:0] c1, logic [7:0] c2);
      logic a;
      bus_start();
      send_byte(8'hD8, a); check("R5 addr ack", a, 1);
      send_byte(c1, a);    check("R5 byte1 ack", a, 1);
      send_byte(c2, a);    check("R5 byte2 ack", a, 1);
      check("R5 released after ack", sda_oe, 0);
      bus_stop();
   endtask

   task automatic t_reset();
      check("R7 reset controls", ctrl_now(), 0);
      check("R7 reset sda", sda_oe, 0);
   endtask

   task automatic t_write_fields();
      int rc;
      rc = rearm_cnt;
      do_write(8'h55, 8'h1A);
      check("R2 first byte fields", ctrl_now(), ctrl_exp(8'h55, 8'h1A));
      do_write(8'hAA, 8'hE5);
      check("R3 ignored bits second byte", ctrl_now(), ctrl_exp(8'hAA, 8'hE5));
      check("R10 no rearm on write", rearm_cnt, rc);
   endtask

   task automatic t_extra_bytes();
      logic a;
      bus_start();
      send_byte(8'hD8, a);
      send_byte(8'h41, a);
      send_byte(8'h10, a);
      send_byte(8'hFF, a); check("R4 extra byte acked", a, 1);
      send_byte(8'h3E, a); check("R4 extra byte acked 2", a, 1);
      bus_stop();
      check("R4 extra bytes ignored", ctrl_now(), ctrl_exp(8'h41, 8'h10));
   endtask

   task automatic t_bad_addr();
      logic a;
      int rc;
      rc = rearm_cnt;
      bus_start();
      send_byte(8'hDA, a); check("R1 wrong addr nack", a, 0);
      send_byte(8'h7F, a); check("R1 no ack after reject", a, 0);
      send_byte(8'h1B, a);
      bus_stop();
      check("R1 controls unchanged", ctrl_now(), ctrl_exp(8'h41, 8'h10));
      bus_start();
      send_byte(8'h5B, a); check("R1 wrong read addr nack", a, 0);
      bus_stop();
      check("R1 no rearm", rearm_cnt, rc);
   endtask

   task automatic t_read_basic();
      logic a;
      logic [7:0] b;
      int rc;
      flags = 20'b10110_01101_11010_00101; therm = 1; cdone = 1; ofsact = 1;
      tick(4);
      rc = rearm_cnt;
      bus_start();
      send_byte(8'hD9, a); check("R5 read addr ack", a, 1);
      for (int k = 0; k < 4; k++) begin
         recv_byte(k != 3, b);
         check($sformatf("R8 R9 byte %0d", k), b,
               stat_exp(k, flags, therm, cdone, ofsact, run, diag_en));
      end
      check("R11 released after nack", sda_oe, 0);
      bus_stop();
      tick(4);
      check("R10 one rearm after read", rearm_cnt, rc + 1);
   endtask

   task automatic t_snapshot();
      logic a;
      logic [7:0] b;
      logic [19:0] old_fl;
      logic old_th;
      old_fl = 20'b01001_10010_00111_11000; old_th = 0;
      flags = old_fl; therm = old_th; cdone = 0; ofsact = 0;
      tick(4);
      bus_start();
      send_byte(8'hD9, a);
      flags = ~old_fl; therm = 1;
      for (int k = 0; k < 4; k++) begin
         recv_byte(k != 3, b);
         check($sformatf("R8 snapshot byte %0d", k), b,
               stat_exp(k, old_fl, old_th, 0, 0, run, diag_en));
      end
      bus_stop();
      bus_start();
      send_byte(8'hD9, a);
      recv_byte(0, b);
      check("R8 next read shows update", b, stat_exp(0, ~old_fl, 1, 0, 0, run, diag_en));
      bus_stop();
   endtask

   task automatic t_wrap_restart();
      logic a;
      logic [7:0] b;
      int rc;
      do_write(8'h40, 8'h10);
      flags = 20'b00011_10100_01010_11111; therm = 0; cdone = 1; ofsact = 0;
      tick(4);
      rc = rearm_cnt;
      bus_start();
      send_byte(8'hD9, a);
      for (int k = 0; k < 5; k++) begin
         recv_byte(k != 4, b);
         if (k == 2) check("R9 byte 2 run and diag", b, stat_exp(2, flags, 0, 1, 0, 1, 1));
         if (k == 4) check("R11 fifth byte wraps", b, stat_exp(0, flags, 0, 1, 0, 1, 1));
      end
      bus_start();
      tick(4);
      check("R10 rearm on repeated start", rearm_cnt, rc + 1);
      send_byte(8'hD8, a); check("R5 ack after repeated start", a, 1);
      send_byte(8'h04, a);
      bus_stop();
      check("R2 write after repeated start", ctrl_now(), ctrl_exp(8'h04, 8'h10));
      check("R10 write closes without rearm", rearm_cnt, rc + 1);
   endtask

   initial begin
      tick(5);
      t_reset();
      rst_n = 1;
      tick(5);
      t_write_fields();
      t_extra_bytes();
      t_bad_addr();
      t_read_basic();
      t_snapshot();
      t_wrap_restart();
      check("R6 drive changed while SCL high", r6_viol, 0);
      check("R7 idle at end", sda_oe, 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule